// File: doc/BRIEF.md
# Synchronous FIFO with programmable flags and replay

A single-clock first-in first-out buffer for 18-bit words with a power-of-two depth (4096 by default). A writer presents a word with an active-low write enable. A reader pulls words with an active-low read enable. The word read appears on the data output after the clock edge that accepted the read, and it stays there until the next accepted read.

Five active-low status outputs describe how full the buffer is: full, empty, nearly full, nearly empty and past-half. The nearly-empty and nearly-full thresholds are distances from the empty and full boundaries. They are held in two offset registers that a strobe, a select bit and a value bus can rewrite. A master reset restores both offsets to a default that is derived from the depth.

A replay pulse rewinds the read side to storage location zero. Everything written since the last reset can then be read out again. Words written after the rewind follow in order, and every flag tracks the rewound pointers.

Top module: `prog_fifo`

## Requirements
- R1: While mrst is high and on the edge that follows it, `empty_n` and `aempty_n` read 0, `full_n`, `afull_n` and `half_n` read 1, `rd_data` reads 0, and both pointers clear.
- R2: Accepted words come out on `rd_data` in the order they were written. Each word is visible after the rising edge that sampled `rd_n` low.
- R3: `full_n` is 0 exactly when the FIFO holds DEPTH words. While it is 0 a write request stores nothing and leaves the contents unchanged.
- R4: `empty_n` is 0 exactly when the FIFO holds no words. While it is 0 a read request is ignored and `rd_data` keeps its value.
- R5: `aempty_n` is 0 exactly when the word count is less than or equal to the empty offset.
- R6: `afull_n` is 0 exactly when the word count is greater than or equal to DEPTH minus the full offset.
- R7: `half_n` is 0 exactly when the word count is greater than DEPTH/2.
- R8: Both offsets reset to min(DEPTH/8 - 1, 127), which is 127 for DEPTH 4096 and 7 for DEPTH 64. A cycle with `ofs_ld` high loads `ofs_val` into the empty offset when `ofs_sel` is 0 and into the full offset when `ofs_sel` is 1. The flags use the new value from that same edge. Offsets span 0 to DEPTH-1.
- R9: A cycle in which both a read and a write are accepted leaves the word count, and therefore every flag, unchanged.
- R10: A cycle with `rewind` high sets the read pointer to location 0, and any read requested in that cycle is ignored. Later reads replay the stored words from the first one onward, and all flags follow the count implied by the pointers. This holds when no more than DEPTH writes have occurred since reset.
- R11: Words written in the same cycle as a rewind, or after it, are delivered in order after the replayed words.
- R12: Every flag is a register output. It changes on the same rising edge that accepts the write or read that alters the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst | input | 1 | Synchronous master reset, active high |
| wr_n | input | 1 | Write request, active low |
| wr_data | input | WIDTH | Word to store |
| rd_n | input | 1 | Read request, active low |
| rd_data | output | WIDTH | Last word read |
| rewind | input | 1 | Replay pulse, active high |
| ofs_ld | input | 1 | Offset load strobe |
| ofs_sel | input | 1 | 0 selects the empty offset, 1 selects the full offset |
| ofs_val | input | log2(DEPTH) | Offset value to load |
| full_n | output | 1 | Full flag, active low |
| empty_n | output | 1 | Empty flag, active low |
| afull_n | output | 1 | Nearly-full flag, active low |
| aempty_n | output | 1 | Nearly-empty flag, active low |
| half_n | output | 1 | Past-half flag, active low |

## Verification
Every result is due one register after its stimulus. Flags, read data and offset effects all appear right after the rising edge that samples the write, read, rewind or load. The bench drives each request on the falling edge and samples 1 ns after the next rising edge, which is the cycle in which the new value first holds. A scoreboard predicts every flag in every cycle from its own word count, including during rewinds. It also predicts each word read from a queue that is rebuilt from the write history when a replay starts.

// File: rtl/prog_fifo_pkg.sv
package prog_fifo_pkg;

    localparam int WORD_W    = 18;
    localparam int DEPTH_DEF = 4096;

    typedef struct packed {
        logic full;
        logic empty;
        logic afull;
        logic aempty;
        logic half;
    } fifo_flags_t;

    typedef enum logic {
        OFS_EMPTY = 1'b0,
        OFS_FULL  = 1'b1
    } ofs_sel_e;

    localparam fifo_flags_t FLAGS_RST = '{full: 1'b0, empty: 1'b1, afull: 1'b0,
                                         aempty: 1'b1, half: 1'b0};

    // default threshold distance for a given depth
    function automatic int unsigned def_offset(int unsigned depth);
        int unsigned v;
        v = depth / 8 - 1;
        return (v > 127) ? 127 : v;
    endfunction

    // active-high flag conditions from a word count
    function automatic fifo_flags_t flag_eval(int unsigned cnt, int unsigned depth,
                                              int unsigned eo, int unsigned fo);
        fifo_flags_t f;
        f.full   = (cnt == depth);
        f.empty  = (cnt == 0);
        f.afull  = (cnt >= depth - fo);
        f.aempty = (cnt <= eo);
        f.half   = (cnt > depth / 2);
        return f;
    endfunction

endpackage

// File: rtl/prog_fifo_store.sv
module prog_fifo_store #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 4096,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/prog_fifo_ofs.sv
module prog_fifo_ofs
    import prog_fifo_pkg::*;
#(
    parameter int DEPTH = 4096,
    parameter int OW    = $clog2(DEPTH),
    parameter int DEF_E = 127,
    parameter int DEF_F = 127
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic          sel,
    input  logic [OW-1:0] val,
    output logic [OW-1:0] eofs_nx,
    output logic [OW-1:0] fofs_nx
);

    for (genvar g = 0; g < 2; g++) begin : g_ofs
        localparam ofs_sel_e      SEL_V = (g == 0) ? OFS_EMPTY : OFS_FULL;
        localparam logic [OW-1:0] DV    = (g == 0) ? OW'(DEF_E) : OW'(DEF_F);
        logic [OW-1:0] q;
        logic [OW-1:0] d;

        always_comb begin
            d = q;
            if (ld && (sel == SEL_V)) begin
                d = val;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= DV;
            end else begin
                q <= d;
            end
        end
    end

    assign eofs_nx = g_ofs[0].d;
    assign fofs_nx = g_ofs[1].d;

endmodule

// File: rtl/prog_fifo_flags.sv
module prog_fifo_flags
    import prog_fifo_pkg::*;
#(
    parameter int DEPTH = 4096,
    parameter int OW    = $clog2(DEPTH),
    parameter int CW    = OW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cnt_nx,
    input  logic [OW-1:0] eofs_nx,
    input  logic [OW-1:0] fofs_nx,
    output fifo_flags_t   flags_q
);

    fifo_flags_t flags_d;

    always_comb begin
        flags_d = flag_eval(32'(cnt_nx), 32'(DEPTH), 32'(eofs_nx), 32'(fofs_nx));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= FLAGS_RST;
        end else begin
            flags_q <= flags_d;
        end
    end

endmodule

// File: rtl/prog_fifo.sv
module prog_fifo
    import prog_fifo_pkg::*;
#(
    parameter int WIDTH         = WORD_W,
    parameter int DEPTH         = DEPTH_DEF,
    parameter int EMPTY_OFS_DEF = def_offset(DEPTH),
    parameter int FULL_OFS_DEF  = def_offset(DEPTH),
    localparam int AW           = $clog2(DEPTH),
    localparam int PW           = AW + 1
) (
    input  logic             clk,
    input  logic             mrst,
    input  logic             wr_n,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_n,
    output logic [WIDTH-1:0] rd_data,
    input  logic             rewind,
    input  logic             ofs_ld,
    input  logic             ofs_sel,
    input  logic [AW-1:0]    ofs_val,
    output logic             full_n,
    output logic             empty_n,
    output logic             afull_n,
    output logic             aempty_n,
    output logic             half_n
);

    fifo_flags_t   flags_q;
    logic [PW-1:0] wptr, rptr, wptr_nx, rptr_nx, cnt_nx;
    logic [AW-1:0] eofs_nx, fofs_nx;
    logic          we, re;

    // requests are qualified by the registered boundary flags
    assign we = !wr_n && !flags_q.full;
    assign re = !rd_n && !flags_q.empty && !rewind;

    always_comb begin
        wptr_nx = wptr + PW'(we);
        rptr_nx = rewind ? '0 : rptr + PW'(re);
        cnt_nx  = wptr_nx - rptr_nx;
    end

    always_ff @(posedge clk) begin
        if (mrst) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            wptr <= wptr_nx;
            rptr <= rptr_nx;
        end
    end

    prog_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk   (clk),
        .rst   (mrst),
        .we    (we),
        .waddr (wptr[AW-1:0]),
        .wdata (wr_data),
        .re    (re),
        .raddr (rptr[AW-1:0]),
        .rdata (rd_data)
    );

    prog_fifo_ofs #(.DEPTH(DEPTH), .OW(AW), .DEF_E(EMPTY_OFS_DEF), .DEF_F(FULL_OFS_DEF)) u_ofs (
        .clk     (clk),
        .rst     (mrst),
        .ld      (ofs_ld),
        .sel     (ofs_sel),
        .val     (ofs_val),
        .eofs_nx (eofs_nx),
        .fofs_nx (fofs_nx)
    );

    prog_fifo_flags #(.DEPTH(DEPTH), .OW(AW), .CW(PW)) u_flags (
        .clk     (clk),
        .rst     (mrst),
        .cnt_nx  (cnt_nx),
        .eofs_nx (eofs_nx),
        .fofs_nx (fofs_nx),
        .flags_q (flags_q)
    );

    assign full_n   = ~flags_q.full;
    assign empty_n  = ~flags_q.empty;
    assign afull_n  = ~flags_q.afull;
    assign aempty_n = ~flags_q.aempty;
    assign half_n   = ~flags_q.half;

endmodule

// File: rtl/prog_fifo_chk.sv
module prog_fifo_chk #(
    parameter int WIDTH = 18
) (
    input logic             clk,
    input logic             mrst,
    input logic             wr_n,
    input logic             rd_n,
    input logic             rewind,
    input logic [WIDTH-1:0] rd_data,
    input logic             full_n,
    input logic             empty_n,
    input logic             afull_n,
    input logic             aempty_n,
    input logic             half_n
);

    // R3
    full_block_chk: assert property (@(posedge clk) disable iff (mrst)
        (!full_n && !wr_n && rd_n && !rewind) |=> !full_n);

    // R4
    rdata_hold_chk: assert property (@(posedge clk) disable iff (mrst)
        (rd_n || !empty_n) |=> $stable(rd_data));

    // R5
    aempty_cover_chk: assert property (@(posedge clk) disable iff (mrst)
        !empty_n |-> !aempty_n);

    // R6
    afull_cover_chk: assert property (@(posedge clk) disable iff (mrst)
        !full_n |-> !afull_n);

    // R7
    half_excl_chk: assert property (@(posedge clk) disable iff (mrst)
        !half_n |-> empty_n);

    // R9
    balanced_chk: assert property (@(posedge clk) disable iff (mrst)
        (empty_n && full_n && !wr_n && !rd_n && !rewind)
        |=> $stable({empty_n, full_n, half_n}));

    // R10
    rewind_fill_chk: assert property (@(posedge clk) disable iff (mrst)
        (rewind && !wr_n && full_n) |=> empty_n);

endmodule

bind prog_fifo prog_fifo_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .mrst     (mrst),
    .wr_n     (wr_n),
    .rd_n     (rd_n),
    .rewind   (rewind),
    .rd_data  (rd_data),
    .full_n   (full_n),
    .empty_n  (empty_n),
    .afull_n  (afull_n),
    .aempty_n (aempty_n),
    .half_n   (half_n)
);

// File: tb/prog_fifo_bench.sv
`timescale 1ns/1ps
module prog_fifo_bench;

    localparam int DEPTH = 64;
    localparam int AW    = 6;
    localparam int W     = 18;
    localparam int DEF_O = 7;

    logic         clk = 1'b0;
    logic         mrst = 1'b1;
    logic         wr_n = 1'b1, rd_n = 1'b1, rewind = 1'b0;
    logic         ofs_ld = 1'b0, ofs_sel = 1'b0;
    logic [AW-1:0] ofs_val = '0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic         full_n, empty_n, afull_n, aempty_n, half_n;

    int total = 0;
    int fails = 0;
    int m_e = DEF_O;
    int m_f = DEF_O;
    int last_rd = 0;
    string phase = "R12";
    logic [W-1:0] exp_q[$];
    logic [W-1:0] hist[$];

    always #2 clk = ~clk;

    prog_fifo #(.WIDTH(W), .DEPTH(DEPTH)) u_prog_fifo (
        .clk(clk), .mrst(mrst), .wr_n(wr_n), .wr_data(wr_data), .rd_n(rd_n),
        .rd_data(rd_data), .rewind(rewind), .ofs_ld(ofs_ld), .ofs_sel(ofs_sel),
        .ofs_val(ofs_val), .full_n(full_n), .empty_n(empty_n), .afull_n(afull_n),
        .aempty_n(aempty_n), .half_n(half_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s [%s] act=%0d exp=%0d at %0t", req, phase, act, exp, $time);
        end
    endtask

    task automatic check_flags();
        int n = exp_q.size();
        chk(full_n   == !(n == DEPTH),        "R3", int'(full_n),   int'(!(n == DEPTH)));
        chk(empty_n  == !(n == 0),            "R4", int'(empty_n),  int'(!(n == 0)));
        chk(aempty_n == !(n <= m_e),          "R5", int'(aempty_n), int'(!(n <= m_e)));
        chk(afull_n  == !(n >= DEPTH - m_f),  "R6", int'(afull_n),  int'(!(n >= DEPTH - m_f)));
        chk(half_n   == !(n > DEPTH / 2),     "R7", int'(half_n),   int'(!(n > DEPTH / 2)));
    endtask

    // driver + scoreboard: one clock cycle of stimulus and its prediction
    task automatic step(input bit w, input int d, input bit r, input bit rw,
                        input bit ld, input bit sel, input int val);
        bit wok, rok;
        int expd = 0;
        @(negedge clk);
        wr_n = !w; wr_data = W'(d); rd_n = !r; rewind = rw;
        ofs_ld = ld; ofs_sel = sel; ofs_val = AW'(val);
        wok = w && (exp_q.size() < DEPTH);
        rok = r && !rw && (exp_q.size() > 0);
        if (rok) expd = int'(exp_q.pop_front());
        if (rw) exp_q = hist;
        if (wok) begin
            exp_q.push_back(W'(d));
            hist.push_back(W'(d));
        end
        if (ld) begin
            if (sel) m_f = val; else m_e = val;
        end
        @(posedge clk);
        #1;
        wr_n = 1'b1; rd_n = 1'b1; rewind = 1'b0; ofs_ld = 1'b0;
        check_flags();
        if (rok) begin
            chk(int'(rd_data) == expd, "R2 data", int'(rd_data), expd);
            last_rd = expd;
        end else begin
            chk(int'(rd_data) == last_rd, "R4 hold", int'(rd_data), last_rd);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        mrst = 1'b1;
        wr_n = 1'b1; rd_n = 1'b1; rewind = 1'b0; ofs_ld = 1'b0;
        repeat (2) @(negedge clk);
        exp_q.delete(); hist.delete();
        m_e = DEF_O; m_f = DEF_O; last_rd = 0;
        phase = "R1";
        chk(empty_n == 1'b0 && aempty_n == 1'b0, "R1 low flags",
            int'({empty_n, aempty_n}), 0);
        chk(full_n && afull_n && half_n, "R1 high flags",
            int'({full_n, afull_n, half_n}), 7);
        chk(rd_data == '0, "R1 rd_data", int'(rd_data), 0);
        mrst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        do_reset();

        // fill to full with default offsets, then write while full
        phase = "R12 R8";
        for (int i = 0; i < DEPTH; i++) step(1, 'h100 + i, 0, 0, 0, 0, 0);
        phase = "R3";
        step(1, 'h3ffff, 0, 0, 0, 0, 0);
        step(1, 'h3fffe, 0, 0, 0, 0, 0);

        // drain a little, then balanced traffic
        phase = "R2";
        for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 0, 0, 0);
        phase = "R9";
        for (int i = 0; i < 10; i++) step(1, 'h2000 + i, 1, 0, 0, 0, 0);

        // empty out, then read while empty
        phase = "R2";
        while (exp_q.size() > 0) step(0, 0, 1, 0, 0, 0, 0);
        phase = "R4";
        for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0, 0, 0);

        // programmed offsets
        do_reset();
        phase = "R8";
        step(0, 0, 0, 0, 1, 0, 20);
        step(1, 'h500, 0, 0, 1, 1, 10);
        for (int i = 0; i < 60; i++) step(1, 'h600 + i, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 1, 2);
        step(0, 0, 0, 0, 1, 0, 63);
        for (int i = 0; i < 61; i++) step(0, 0, 1, 0, 0, 0, 0);

        // partial replay with writes after the rewind
        do_reset();
        phase = "R10";
        for (int i = 0; i < 20; i++) step(1, 'h1000 + i, 0, 0, 0, 0, 0);
        for (int i = 0; i < 8; i++) step(0, 0, 1, 0, 0, 0, 0);
        step(0, 0, 1, 1, 0, 0, 0);
        for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 0, 0, 0);
        phase = "R11";
        for (int i = 0; i < 10; i++) step(1, 'h1800 + i, 0, 0, 0, 0, 0);
        step(1, 'h1900, 0, 1, 0, 0, 0);
        while (exp_q.size() > 0) step(0, 0, 1, 0, 0, 0, 0);

        // replay of a full depth
        do_reset();
        phase = "R10 full";
        for (int i = 0; i < DEPTH; i++) step(1, 'h3000 + i, 0, 0, 0, 0, 0);
        for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 1, 0, 0, 0, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule